// File: doc/BRIEF.md
# Serial Audio Port Control and Status Register

This block is the control and status word for one direction (transmit or receive) of a serial audio port. Software reaches it through a plain 32-bit register port. A write takes effect at the next clock edge. The read data is always presented, taken directly from the held state and the live FIFO indications. The serial shifter and the FIFO sit beside the block. The shifter reports word starts, frame-sync errors and frame completion as one-cycle pulses. The FIFO reports an error pulse (underrun or overflow) and two level signals: a warning (empty for transmit, full for receive) and a watermark request.

Each of the five status flags has an interrupt-enable bit eight positions below it in the same word. The interrupt line is the OR of every flag gated by its own enable. Three of the flags are sticky and are cleared by writing 1 to them. The other two follow the FIFO live. The word also holds four controls. The DMA request enable gates the watermark onto a DMA request line. The FIFO flush bit produces a single flush pulse. The software reset bit holds the rest of the block cleared for as long as it is set. The port enable bit turns on at once when written high, but when written low it keeps reading 1 until the frame in progress finishes.

Top module: `audio_csr`

## Requirements
- R1: After rst_n is held low through a clock edge, rd_data reads 0 and irq, dma_req, port_en, fifo_flush and soft_rst are all low.
- R2: Bit layout. Bit 0 is the DMA request enable, bit 24 is the FIFO flush, bit 25 is the software reset, and bit 31 is the port enable. Bits 8 to 12 are the interrupt enables and bits 16 to 20 are the status flags, each flag sitting 8 bits above its enable. Flag order from the low end is: word start, sync error, FIFO error, FIFO warning, FIFO watermark. All other bits read 0.
- R3: A pulse on ev_pulse[i] (0 word start, 1 sync error, 2 FIFO error) sets flag bit 16+i at the next edge, whatever the enable bits hold. The flag then stays set until it is cleared.
- R4: Writing 1 to bit 16, 17 or 18 clears that sticky flag, and writing 0 to it leaves it unchanged. When an event pulse arrives in the same cycle as the clearing write, the flag stays set.
- R5: Bits 19 and 20 read fifo_warn and fifo_wm live. Writes to these two bits have no effect.
- R6: irq is high exactly when some flag bit (16 to 20) and its enable bit (8 to 12) are both 1.
- R7: dma_req equals bit 0 ANDed with fifo_wm.
- R8: Writing bit 31 high sets port_en at the next edge. Writing it low while it is set leaves port_en and bit 31 at 1 until the first frame_end pulse seen in or after the write cycle, and they drop at that edge. Writing bit 31 high again before that pulse cancels the pending disable.
- R9: Writing 1 to bit 24 drives fifo_flush high for exactly the one cycle after the write. Bit 24 always reads 0.
- R10: Writing 1 to bit 25 sets soft_rst and clears every other bit at that same edge. While soft_rst is set, rd_data reads only bit 25, event pulses and writes to other bits are ignored, and irq, dma_req, port_en and fifo_flush stay low. Writing 0 to bit 25 releases the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| ev_pulse | input | 3 | Event pulses: 0 word start, 1 sync error, 2 FIFO error |
| fifo_warn | input | 1 | Live FIFO empty (transmit) or full (receive) |
| fifo_wm | input | 1 | Live FIFO watermark reached |
| frame_end | input | 1 | Pulse from the shifter when a frame completes |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| port_en | output | 1 | Effective port enable to the shifter |
| fifo_flush | output | 1 | One-cycle FIFO flush pulse |
| soft_rst | output | 1 | Software reset level to the port logic |

## Verification
A lost pending disable shows on port_en in the cycle after the write, because the port then turns off before the frame has ended. A stuck pending state shows as port_en staying high past the frame_end pulse. A sticky flag with the wrong set or clear priority changes the readback and irq one edge after the colliding write. A soft reset that fails to hold the block shows in rd_data bits other than 25 in the first cycle that an event or write arrives during the reset. A flush bit that is latched instead of pulsed shows when fifo_flush is still high two cycles after the write.

// File: rtl/audio_csr_pkg.sv
// Package: field positions and counts for the audio port control/status word.
// Assumes a single 32-bit register; all positions below are behaviour that the
// surrounding port logic and software decode.
package audio_csr_pkg;
    localparam int DATA_W     = 32;
    localparam int N_STICKY   = 3;                     // word start, sync err, fifo err
    localparam int N_LIVE     = 2;                     // fifo warning, watermark
    localparam int N_FLAG     = N_STICKY + N_LIVE;
    localparam int IE_LSB     = 8;
    localparam int FLAG_SHIFT = 8;
    localparam int FLAG_LSB   = IE_LSB + FLAG_SHIFT;
    localparam int DMAE_BIT   = 0;
    localparam int FLUSH_BIT  = 24;
    localparam int SRST_BIT   = 25;
    localparam int EN_BIT     = 31;

    typedef enum logic [2:0] {
        FLG_WSTART = 3'd0,
        FLG_SYNC   = 3'd1,
        FLG_FERR   = 3'd2,
        FLG_WARN   = 3'd3,
        FLG_WM     = 3'd4
    } flag_idx_e;
endpackage

// File: rtl/sticky_flags.sv
// Module: bank of write-1-to-clear sticky flags.
// Assumes set and clear are single-cycle strobes; a set in the same cycle as
// a clear wins. hold_clr forces every flag to 0 (software reset).
module sticky_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_clr,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Purpose: hold one flag; set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n || hold_clr)
                flags_o[i] <= 1'b0;
            else if (set_i[i])
                flags_o[i] <= 1'b1;
            else if (clr_i[i])
                flags_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/port_enable_ctl.sv
// Module: port enable with deferred turn-off.
// Assumes frame_end is a one-cycle pulse from the shifter. A write of 0 while
// enabled arms a pending disable that completes at the first frame_end seen in
// or after the write cycle; a write of 1 cancels it.
module port_enable_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_clr,
    input  logic wr_en,
    input  logic wr_val,
    input  logic frame_end,
    output logic en_o
);
    logic pend_q;
    logic dis_req;

    // Purpose: a disable is requested by a fresh write or an armed pending one.
    always_comb dis_req = pend_q | (wr_en & ~wr_val & en_o);

    // Purpose: track the effective enable and the pending disable.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_clr) begin
            en_o   <= 1'b0;
            pend_q <= 1'b0;
        end else if (wr_en && wr_val) begin
            en_o   <= 1'b1;
            pend_q <= 1'b0;
        end else if (dis_req && frame_end) begin
            en_o   <= 1'b0;
            pend_q <= 1'b0;
        end else if (dis_req) begin
            pend_q <= 1'b1;
        end
    end
endmodule

// File: rtl/audio_csr.sv
// Module: control/status register for one direction of a serial audio port.
// Assumes one write per wr_en cycle and that reads are served from rd_data at
// any time. Event inputs are one-cycle pulses; fifo_warn and fifo_wm are levels.
module audio_csr
    import audio_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [N_STICKY-1:0] ev_pulse,
    input  logic              fifo_warn,
    input  logic              fifo_wm,
    input  logic              frame_end,
    output logic              irq,
    output logic              dma_req,
    output logic              port_en,
    output logic              fifo_flush,
    output logic              soft_rst
);
    logic [N_FLAG-1:0]   ie_q;
    logic                dmae_q;
    logic                srst_q;
    logic                flush_q;
    logic                hold;
    logic                wr_ok;
    logic [N_STICKY-1:0] sticky;
    logic [N_STICKY-1:0] clr_req;
    logic [N_STICKY-1:0] set_req;
    logic [N_FLAG-1:0]   flags;

    // Purpose: soft reset is in force now or is being written this cycle.
    always_comb hold = srst_q | (wr_en & wr_data[SRST_BIT]);

    // Purpose: writes to fields other than soft reset only count outside it.
    always_comb wr_ok = wr_en & ~hold;

    // Purpose: decode write-1 clears and gate event pulses.
    always_comb begin
        clr_req = wr_ok ? wr_data[FLAG_LSB +: N_STICKY] : '0;
        set_req = ev_pulse;
    end

    sticky_flags #(.N(N_STICKY)) u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_clr (hold),
        .set_i    (set_req),
        .clr_i    (clr_req),
        .flags_o  (sticky)
    );

    port_enable_ctl u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_clr  (hold),
        .wr_en     (wr_ok),
        .wr_val    (wr_data[EN_BIT]),
        .frame_end (frame_end),
        .en_o      (port_en)
    );

    // Purpose: software reset bit, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            srst_q <= 1'b0;
        else if (wr_en)
            srst_q <= wr_data[SRST_BIT];
    end

    // Purpose: interrupt enables and DMA enable, cleared under soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            ie_q   <= '0;
            dmae_q <= 1'b0;
        end else if (wr_ok) begin
            ie_q   <= wr_data[IE_LSB +: N_FLAG];
            dmae_q <= wr_data[DMAE_BIT];
        end
    end

    // Purpose: one-cycle FIFO flush pulse after a write of the flush bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flush_q <= 1'b0;
        else
            flush_q <= wr_ok & wr_data[FLUSH_BIT];
    end

    // Purpose: full flag vector; live FIFO flags are masked under soft reset.
    always_comb begin
        flags                   = '0;
        flags[N_STICKY-1:0]     = sticky;
        flags[FLG_WARN]         = fifo_warn & ~srst_q;
        flags[FLG_WM]           = fifo_wm & ~srst_q;
    end

    // Purpose: assemble the readback word.
    always_comb begin
        rd_data                          = '0;
        rd_data[DMAE_BIT]                = dmae_q;
        rd_data[IE_LSB +: N_FLAG]        = ie_q;
        rd_data[FLAG_LSB +: N_FLAG]      = flags;
        rd_data[SRST_BIT]                = srst_q;
        rd_data[EN_BIT]                  = port_en;
    end

    // Purpose: side outputs to the interrupt controller, DMA and port logic.
    always_comb begin
        irq        = |(flags & ie_q);
        dma_req    = dmae_q & fifo_wm;
        fifo_flush = flush_q;
        soft_rst   = srst_q;
    end
endmodule

// File: rtl/audio_csr_chk.sv
// Checker: port-level properties of audio_csr, bound into every instance.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module audio_csr_chk
    import audio_csr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [N_STICKY-1:0] ev_pulse,
    input logic              fifo_warn,
    input logic              fifo_wm,
    input logic              frame_end,
    input logic              irq,
    input logic              dma_req,
    input logic              port_en,
    input logic              fifo_flush,
    input logic              soft_rst
);
    logic [DATA_W-1:0] not_srst_mask;
    always_comb begin
        not_srst_mask           = '1;
        not_srst_mask[SRST_BIT] = 1'b0;
    end

    // R3: an event outside soft reset shows as a set flag at the next edge.
    for (genvar i = 0; i < N_STICKY; i++) begin : g_ev
        assert_event_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_pulse[i] && !soft_rst && !(wr_en && wr_data[SRST_BIT]))
            |=> rd_data[FLAG_LSB + i]);
    end

    // R8: the enable only falls at a frame end or a soft reset write.
    assert_en_drop_at_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en && !frame_end && !(wr_en && wr_data[SRST_BIT])) |=> port_en);

    // R7: no DMA request without a watermark.
    assert_dma_needs_wm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> fifo_wm);

    // R9: flush pulse follows a flush write and lasts one cycle.
    assert_flush_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> !fifo_flush);

    // R10: under soft reset nothing else reads back and outputs stay quiet.
    assert_srst_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> ((rd_data & not_srst_mask) == '0 && !irq && !dma_req && !port_en));

    // R6: an interrupt needs at least one flag bit set.
    assert_irq_has_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rd_data[FLAG_LSB +: N_FLAG] != '0));
endmodule

bind audio_csr audio_csr_chk u_chk (.*);

// File: tb/sim_audio_csr.sv
module sim_audio_csr;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [2:0]  ev_pulse = '0;
    logic        fifo_warn = 1'b0;
    logic        fifo_wm = 1'b0;
    logic        frame_end = 1'b0;
    logic        irq, dma_req, port_en, fifo_flush, soft_rst;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_csr u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ev_pulse(ev_pulse), .fifo_warn(fifo_warn),
        .fifo_wm(fifo_wm), .frame_end(frame_end), .irq(irq),
        .dma_req(dma_req), .port_en(port_en), .fifo_flush(fifo_flush),
        .soft_rst(soft_rst)
    );

    // {wr, data, ev, warn, wm, frame_end, exp_rd, exp_irq, exp_dma, exp_en}
    localparam logic [73:0] VEC [NV] = '{
        {1'b1, 32'h0000_0100, 3'b000, 1'b0, 1'b0, 1'b0, 32'h0000_0100, 1'b0, 1'b0, 1'b0},
        {1'b0, 32'h0000_0000, 3'b001, 1'b0, 1'b0, 1'b0, 32'h0001_0100, 1'b1, 1'b0, 1'b0},
        {1'b1, 32'h0001_0100, 3'b000, 1'b0, 1'b0, 1'b0, 32'h0000_0100, 1'b0, 1'b0, 1'b0},
        {1'b1, 32'h0001_0100, 3'b001, 1'b0, 1'b0, 1'b0, 32'h0001_0100, 1'b1, 1'b0, 1'b0},
        {1'b1, 32'h0001_0000, 3'b000, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0},
        {1'b0, 32'h0000_0000, 3'b010, 1'b0, 1'b0, 1'b0, 32'h0002_0000, 1'b0, 1'b0, 1'b0},
        {1'b1, 32'h0000_1000, 3'b000, 1'b0, 1'b1, 1'b0, 32'h0012_1000, 1'b1, 1'b0, 1'b0},
        {1'b1, 32'h0010_1001, 3'b000, 1'b0, 1'b1, 1'b0, 32'h0012_1001, 1'b1, 1'b1, 1'b0},
        {1'b0, 32'h0000_0000, 3'b000, 1'b0, 1'b0, 1'b0, 32'h0002_1001, 1'b0, 1'b0, 1'b0},
        {1'b1, 32'h8002_0000, 3'b000, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b0, 1'b0, 1'b1},
        {1'b1, 32'h0000_0000, 3'b000, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b0, 1'b0, 1'b1},
        {1'b0, 32'h0000_0000, 3'b000, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0},
        {1'b1, 32'h8000_0000, 3'b000, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b0, 1'b0, 1'b1},
        {1'b1, 32'h0000_0000, 3'b000, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b0, 1'b0, 1'b1},
        {1'b1, 32'h8000_0000, 3'b000, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b0, 1'b0, 1'b1},
        {1'b0, 32'h0000_0000, 3'b000, 1'b0, 1'b0, 1'b1, 32'h8000_0000, 1'b0, 1'b0, 1'b1},
        {1'b1, 32'h0000_0000, 3'b000, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0},
        {1'b0, 32'h0000_0000, 3'b000, 1'b1, 1'b0, 1'b0, 32'h0008_0000, 1'b0, 1'b0, 1'b0},
        {1'b1, 32'h0000_0400, 3'b100, 1'b0, 1'b0, 1'b0, 32'h0004_0400, 1'b1, 1'b0, 1'b0},
        {1'b1, 32'h0004_0000, 3'b000, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0}
    };
    localparam string VTAG [NV] = '{
        "R2", "R3", "R4", "R4", "R6", "R3", "R5", "R7", "R7", "R8",
        "R8", "R8", "R8", "R8", "R8", "R8", "R8", "R5", "R6", "R4"
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge, return after the next falling edge.
    task automatic cyc(input logic w, input logic [31:0] d, input logic [2:0] ev,
                       input logic fe);
        wr_en = w; wr_data = d; ev_pulse = ev; frame_end = fe;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; ev_pulse = '0; frame_end = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "rd_data", rd_data, 32'h0);
        chk("R1", "outputs", {27'b0, irq, dma_req, port_en, fifo_flush, soft_rst}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [73:0] v;
            v = VEC[i];
            fifo_warn = v[37];
            fifo_wm   = v[36];
            cyc(v[73], v[72:41], v[40:38], v[35]);
            chk(VTAG[i], $sformatf("vec%0d rd_data", i), rd_data, v[34:3]);
            chk(VTAG[i], $sformatf("vec%0d irq", i), {31'b0, irq}, {31'b0, v[2]});
            chk(VTAG[i], $sformatf("vec%0d dma_req", i), {31'b0, dma_req}, {31'b0, v[1]});
            chk(VTAG[i], $sformatf("vec%0d port_en", i), {31'b0, port_en}, {31'b0, v[0]});
        end
        fifo_warn = 1'b0;
        fifo_wm   = 1'b0;

        // R9: flush is a one-cycle pulse and reads 0
        cyc(1'b1, 32'h0100_0000, 3'b000, 1'b0);
        chk("R9", "flush pulse", {31'b0, fifo_flush}, 32'h1);
        chk("R9", "flush readback", rd_data, 32'h0);
        @(negedge clk);
        chk("R9", "flush ended", {31'b0, fifo_flush}, 32'h0);

        // R10: soft reset clears everything and holds it
        cyc(1'b1, 32'h8000_0701, 3'b000, 1'b0);
        cyc(1'b0, 32'h0, 3'b011, 1'b0);
        chk("R10", "setup", rd_data, 32'h8003_0701);
        cyc(1'b1, 32'h0200_0000, 3'b000, 1'b0);
        chk("R10", "enter rd_data", rd_data, 32'h0200_0000);
        chk("R10", "enter soft_rst/port_en/irq", {29'b0, soft_rst, port_en, irq}, 32'h4);
        fifo_wm = 1'b1;
        fifo_warn = 1'b1;
        cyc(1'b1, 32'h8200_1F01, 3'b111, 1'b0);
        chk("R10", "held rd_data", rd_data, 32'h0200_0000);
        chk("R10", "held outputs", {29'b0, irq, dma_req, port_en}, 32'h0);
        fifo_wm = 1'b0;
        fifo_warn = 1'b0;
        cyc(1'b1, 32'h0000_0000, 3'b000, 1'b0);
        chk("R10", "release", {rd_data[31:1], soft_rst}, 32'h0);
        cyc(1'b1, 32'h0000_0100, 3'b001, 1'b0);
        chk("R10", "works after release", rd_data, 32'h0001_0100);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule